// File: doc/BRIEF.md
# Tamper Event Controller with Write Locks

This block supervises tamper events for a chip. Outside detectors deliver one-cycle event pulses for eight internal sources and for a set of tamper pins. Each pulse sets a sticky source flag. A source flag raises the master tamper flag only when software has enabled that source for detection. The flags, a set of interrupt enables and a control bit together drive one interrupt line and a request to force a system reset. When the master flag first rises, the block records the value of an outside seconds counter.

Software uses a small single-cycle register bus with a word address, write data, a write strobe and combinational read data. Every configuration register has a lock bit. A lock bit reads 1 while its register is writable. Software can only clear a lock bit. All lock bits return to 1 after a software reset or a power-on reset. An update-mode control bit lets software still clear the status flags after the status lock is cleared, but only while no tamper is active.

Register word addresses: 0 control, 1 status, 2 lock, 3 interrupt enable, 4 tamper seconds, 5 detect enable, 6 pin direction, 7 pin polarity.

Top module: `tamper_supervisor`

## Requirements
- R1: An event pulse sets its status flag on the clock edge where the pulse is sampled, whether or not detection is enabled for it. The internal sources `src_evt_i[0..7]` map to status bits 2..9: time overflow, monotonic overflow, voltage, clock, temperature, security, flash security and test mode. Pin n maps to status bit 16+n.
- R2: The master flag is status bit 0. It sets in the same cycle as any source flag whose detect-enable bit (same bit position, address 5) is 1. It never sets from a flag whose detect-enable bit is 0.
- R3: Status flags are write-1-to-clear. Writing 1 to bit 0 clears the master flag only if no flag with detection enabled remains set after that write.
- R4: `irq_o` is 1 when either of these holds: interrupt-enable bit 0 (address 3) is 1 and the master flag is set, or a source flag is set and the interrupt-enable bit at that flag's position is 1.
- R5: `force_rst_o` equals control bit 2 ANDed with the master flag.
- R6: The acknowledge flag is status bit 1. A `chip_rst_i` pulse sets it while the master flag is set. It is always 0 while the master flag is clear. A `chip_rst_i` pulse while the master flag is clear has no effect on it.
- R7: The lock register (address 2) implements bits 4..11, and they reset to 1. A write can only clear lock bits, never set them. Writes to the lock register are ignored while lock bit 6 is 0.
- R8: A lock bit at 0 makes its register ignore writes: bit 4 control, bit 5 status, bit 7 interrupt enable, bit 8 tamper seconds, bit 9 detect enable, bit 10 pin direction, bit 11 pin polarity.
- R9: When status lock bit 5 is 0, status writes are still accepted if control bit 3 (update mode) is 1 and the master flag is clear. Otherwise they are ignored.
- R10: On the clock edge where the master flag rises, `secs_i` is captured into the tamper seconds register (address 4).
- R11: Writing 1 to control bit 0 while control is unlocked resets every register of the block, locks included, to its reset value. Control bit 0 always reads 0.
- R12: Control bit 1 drives `presc_en_o`. Control bits 31:17 hold a 15-bit prescaler value driven on `presc_val_o`. Pin direction and pin polarity bits [PIN_CNT-1:0] drive `pin_dir_o` and `pin_pol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_evt_i | input | 8 | Internal source event pulses |
| pin_evt_i | input | PIN_CNT | Tamper pin event pulses |
| chip_rst_i | input | 1 | Pulse telling the block that a chip reset took place |
| secs_i | input | SECS_W | Seconds counter value |
| irq_o | output | 1 | Tamper interrupt |
| force_rst_o | output | 1 | Forced system reset request |
| presc_en_o | output | 1 | Prescaler clock enable |
| presc_val_o | output | 15 | Prescaler value |
| pin_dir_o | output | PIN_CNT | Pin direction, 1 = output |
| pin_pol_o | output | PIN_CNT | Pin polarity, 1 = inverted |

## Verification
The embedded assertions check on every cycle that each event pulse is latched, and that a rising master flag always has an enabled flag behind it. They also check that a chip reset seen during tamper raises the acknowledge flag, that lock bits never come back on their own, that locked registers keep their value, and that the seconds capture lines up with the master rise. The bench scenarios are the only place that shows the value-level outcomes. These include the rule that a master clear is refused while an enabled flag remains, the two update-mode cases, the interrupt and reset outputs under each enable, and a software reset restoring cleared locks.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned ADDR_W    = 3;
   localparam int unsigned SRC_CNT   = 8;
   localparam int unsigned SRC_BASE  = 2;
   localparam int unsigned PIN_BASE  = 16;
   localparam int unsigned MST_BIT   = 0;
   localparam int unsigned ACK_BIT   = 1;
   // lock bit positions
   localparam int unsigned LK_CTRL   = 4;
   localparam int unsigned LK_STAT   = 5;
   localparam int unsigned LK_LOCK   = 6;
   localparam int unsigned LK_IRQ    = 7;
   localparam int unsigned LK_SECS   = 8;
   localparam int unsigned LK_DET    = 9;
   localparam int unsigned LK_DIR    = 10;
   localparam int unsigned LK_POL    = 11;
   // control bit positions
   localparam int unsigned C_SWR     = 0;
   localparam int unsigned C_PEN     = 1;
   localparam int unsigned C_FRST    = 2;
   localparam int unsigned C_UPD     = 3;
   localparam int unsigned PRESC_LSB = 17;
   localparam int unsigned PRESC_W   = 15;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_STAT  = 3'd1,
      A_LOCK  = 3'd2,
      A_IRQEN = 3'd3,
      A_SECS  = 3'd4,
      A_DETEN = 3'd5,
      A_DIR   = 3'd6,
      A_POL   = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic [PRESC_W-1:0] presc;
      logic               upd_mode;
      logic               force_en;
      logic               presc_en;
   } ctrl_t;

   function automatic logic [BUS_W-1:0] field_mask(input int unsigned lsb, input int unsigned width);
      logic [63:0] m;
      m = ((64'd1 << width) - 64'd1) << lsb;
      return m[BUS_W-1:0];
   endfunction
endpackage

// File: rtl/tamper_lockbank.sv
module tamper_lockbank
   import tamper_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst_i,
   input  logic             wr_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] lock_o
);
   localparam logic [BUS_W-1:0] LOCK_MASK = field_mask(LK_CTRL, LK_POL - LK_CTRL + 1);

   logic [BUS_W-1:0] lock_q;
   logic             accept;

   assign accept = wr_i && lock_q[LK_LOCK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lock_q <= LOCK_MASK;
      else if (soft_rst_i) lock_q <= LOCK_MASK;
      else if (accept)     lock_q <= lock_q & wdata_i;
   end

   assign lock_o = lock_q;

   // R7
   lock_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(soft_rst_i) |-> ((lock_q & ~$past(lock_q)) == '0));
endmodule

// File: rtl/tamper_cfgregs.sv
module tamper_cfgregs
   import tamper_pkg::*;
#(
   parameter int unsigned PIN_CNT = 8,
   parameter int unsigned SECS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              we_i,
   input  reg_sel_e          sel_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic [BUS_W-1:0]  lock_i,
   input  logic              master_rise_i,
   input  logic [SECS_W-1:0] secs_i,
   output ctrl_t             ctrl_o,
   output logic [BUS_W-1:0]  det_en_o,
   output logic [BUS_W-1:0]  irq_en_o,
   output logic [SECS_W-1:0] secs_o,
   output logic [PIN_CNT-1:0] dir_o,
   output logic [PIN_CNT-1:0] pol_o
);
   localparam logic [BUS_W-1:0] DET_MASK = field_mask(SRC_BASE, SRC_CNT) | field_mask(PIN_BASE, PIN_CNT);
   localparam logic [BUS_W-1:0] IRQ_MASK = DET_MASK | field_mask(MST_BIT, 1);

   ctrl_t              ctrl_q;
   logic [BUS_W-1:0]   det_q, irq_q;
   logic [SECS_W-1:0]  secs_q;
   logic [PIN_CNT-1:0] dir_q, pol_q;

   logic hit_ctrl, hit_irq, hit_secs, hit_det, hit_dir, hit_pol;

   assign hit_ctrl = we_i && (sel_i == A_CTRL)  && lock_i[LK_CTRL];
   assign hit_irq  = we_i && (sel_i == A_IRQEN) && lock_i[LK_IRQ];
   assign hit_secs = we_i && (sel_i == A_SECS)  && lock_i[LK_SECS];
   assign hit_det  = we_i && (sel_i == A_DETEN) && lock_i[LK_DET];
   assign hit_dir  = we_i && (sel_i == A_DIR)   && lock_i[LK_DIR];
   assign hit_pol  = we_i && (sel_i == A_POL)   && lock_i[LK_POL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         det_q  <= '0;
         irq_q  <= '0;
         secs_q <= '0;
         dir_q  <= '0;
         pol_q  <= '0;
      end else if (soft_rst_i) begin
         ctrl_q <= '0;
         det_q  <= '0;
         irq_q  <= '0;
         secs_q <= '0;
         dir_q  <= '0;
         pol_q  <= '0;
      end else begin
         if (hit_ctrl) begin
            ctrl_q.presc    <= wdata_i[PRESC_LSB +: PRESC_W];
            ctrl_q.upd_mode <= wdata_i[C_UPD];
            ctrl_q.force_en <= wdata_i[C_FRST];
            ctrl_q.presc_en <= wdata_i[C_PEN];
         end
         if (hit_det) det_q <= wdata_i & DET_MASK;
         if (hit_irq) irq_q <= wdata_i & IRQ_MASK;
         if (master_rise_i)  secs_q <= secs_i;
         else if (hit_secs)  secs_q <= wdata_i[SECS_W-1:0];
         if (hit_dir) dir_q <= wdata_i[PIN_CNT-1:0];
         if (hit_pol) pol_q <= wdata_i[PIN_CNT-1:0];
      end
   end

   assign ctrl_o   = ctrl_q;
   assign det_en_o = det_q;
   assign irq_en_o = irq_q;
   assign secs_o   = secs_q;
   assign dir_o    = dir_q;
   assign pol_o    = pol_q;

   // R8
   ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_i[LK_CTRL] |=> $stable(ctrl_q));
   // R8
   det_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_i[LK_DET] && !soft_rst_i) |=> $stable(det_q));
endmodule

// File: rtl/tamper_flagcore.sv
module tamper_flagcore
   import tamper_pkg::*;
#(
   parameter int unsigned PIN_CNT = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst_i,
   input  logic [SRC_CNT-1:0] src_evt_i,
   input  logic [PIN_CNT-1:0] pin_evt_i,
   input  logic               chip_rst_i,
   input  logic               stat_wr_i,
   input  logic [BUS_W-1:0]   wdata_i,
   input  logic [BUS_W-1:0]   det_en_i,
   input  logic [BUS_W-1:0]   irq_en_i,
   input  logic               force_en_i,
   output logic [BUS_W-1:0]   status_o,
   output logic               master_o,
   output logic               master_rise_o,
   output logic               irq_o,
   output logic               force_rst_o
);
   localparam logic [BUS_W-1:0] FLAG_MASK = field_mask(SRC_BASE, SRC_CNT) | field_mask(PIN_BASE, PIN_CNT);

   logic [BUS_W-1:0] flag_q, flag_d, evt_vec, clr_vec;
   logic             mst_q, mst_d, ack_q, ack_d, irq_comb;

   always_comb begin
      evt_vec = '0;
      evt_vec[SRC_BASE +: SRC_CNT] = src_evt_i;
      evt_vec[PIN_BASE +: PIN_CNT] = pin_evt_i;
      clr_vec = stat_wr_i ? wdata_i : '0;
      flag_d  = (flag_q & ~(clr_vec & FLAG_MASK)) | evt_vec;
      mst_d   = (|(flag_d & det_en_i)) || (mst_q && !clr_vec[MST_BIT]);
      ack_d   = mst_d && ((ack_q && !clr_vec[ACK_BIT]) || (chip_rst_i && mst_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         mst_q  <= 1'b0;
         ack_q  <= 1'b0;
      end else if (soft_rst_i) begin
         flag_q <= '0;
         mst_q  <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         mst_q  <= mst_d;
         ack_q  <= ack_d;
      end
   end

   assign irq_comb      = (mst_q && irq_en_i[MST_BIT]) || (|(flag_q & irq_en_i & FLAG_MASK));
   assign master_rise_o = mst_d && !mst_q && !soft_rst_i;
   assign master_o      = mst_q;
   assign force_rst_o   = force_en_i && mst_q;

   always_comb begin
      status_o          = flag_q;
      status_o[MST_BIT] = mst_q;
      status_o[ACK_BIT] = ack_q;
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          irq_q <= 1'b0;
            else if (soft_rst_i) irq_q <= 1'b0;
            else                 irq_q <= irq_comb;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_comb;
      end
   endgenerate

   // R1
   evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|src_evt_i) && !soft_rst_i) |=>
         ((flag_q[SRC_BASE +: SRC_CNT] & $past(src_evt_i)) == $past(src_evt_i)));
   // R2
   master_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mst_q) |-> (|(flag_q & $past(det_en_i))));
   // R6
   ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_rst_i && mst_q && !soft_rst_i && !stat_wr_i) |=> ack_q);
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
   import tamper_pkg::*;
#(
   parameter int unsigned PIN_CNT = 8,
   parameter int unsigned SECS_W  = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_we,
   output logic [31:0]        bus_rdata,
   input  logic [7:0]         src_evt_i,
   input  logic [PIN_CNT-1:0] pin_evt_i,
   input  logic               chip_rst_i,
   input  logic [SECS_W-1:0]  secs_i,
   output logic               irq_o,
   output logic               force_rst_o,
   output logic               presc_en_o,
   output logic [14:0]        presc_val_o,
   output logic [PIN_CNT-1:0] pin_dir_o,
   output logic [PIN_CNT-1:0] pin_pol_o
);
   generate
      if (PIN_CNT < 1 || PIN_CNT > 16) begin : g_bad_pins
         $error("PIN_CNT must lie in 1..16");
      end
      if (SECS_W < 1 || SECS_W > BUS_W) begin : g_bad_secs
         $error("SECS_W must lie in 1..BUS_W");
      end
   endgenerate

   reg_sel_e            sel;
   logic                soft_rst, lock_wr, stat_wr, master, master_rise;
   logic [BUS_W-1:0]    lock, det_en, irq_en, status;
   logic [SECS_W-1:0]   secs;
   ctrl_t               ctrl;

   assign sel      = reg_sel_e'(bus_addr);
   assign soft_rst = bus_we && (sel == A_CTRL) && lock[LK_CTRL] && bus_wdata[C_SWR];
   assign lock_wr  = bus_we && (sel == A_LOCK);
   assign stat_wr  = bus_we && (sel == A_STAT) &&
                     (lock[LK_STAT] || (ctrl.upd_mode && !master));

   tamper_lockbank u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst),
      .wr_i       (lock_wr),
      .wdata_i    (bus_wdata),
      .lock_o     (lock)
   );

   tamper_cfgregs #(.PIN_CNT(PIN_CNT), .SECS_W(SECS_W)) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .soft_rst_i    (soft_rst),
      .we_i          (bus_we),
      .sel_i         (sel),
      .wdata_i       (bus_wdata),
      .lock_i        (lock),
      .master_rise_i (master_rise),
      .secs_i        (secs_i),
      .ctrl_o        (ctrl),
      .det_en_o      (det_en),
      .irq_en_o      (irq_en),
      .secs_o        (secs),
      .dir_o         (pin_dir_o),
      .pol_o         (pin_pol_o)
   );

   tamper_flagcore #(.PIN_CNT(PIN_CNT), .IRQ_REG(IRQ_REG)) u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .soft_rst_i    (soft_rst),
      .src_evt_i     (src_evt_i),
      .pin_evt_i     (pin_evt_i),
      .chip_rst_i    (chip_rst_i),
      .stat_wr_i     (stat_wr),
      .wdata_i       (bus_wdata),
      .det_en_i      (det_en),
      .irq_en_i      (irq_en),
      .force_en_i    (ctrl.force_en),
      .status_o      (status),
      .master_o      (master),
      .master_rise_o (master_rise),
      .irq_o         (irq_o),
      .force_rst_o   (force_rst_o)
   );

   always_comb begin
      unique case (sel)
         A_CTRL:  bus_rdata = {ctrl.presc, 13'd0, ctrl.upd_mode, ctrl.force_en, ctrl.presc_en, 1'b0};
         A_STAT:  bus_rdata = status;
         A_LOCK:  bus_rdata = lock;
         A_IRQEN: bus_rdata = irq_en;
         A_SECS:  bus_rdata = BUS_W'(secs);
         A_DETEN: bus_rdata = det_en;
         A_DIR:   bus_rdata = BUS_W'(pin_dir_o);
         A_POL:   bus_rdata = BUS_W'(pin_pol_o);
         default: bus_rdata = '0;
      endcase
   end

   assign presc_en_o  = ctrl.presc_en;
   assign presc_val_o = ctrl.presc;

   // R10
   secs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(master) |-> (secs == $past(secs_i)));
endmodule

// File: tb/tamper_supervisor_bench.sv
module tamper_supervisor_bench;
   localparam int PINS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [7:0]  src_evt = '0;
   logic [PINS-1:0] pin_evt = '0;
   logic        chip_rst = 1'b0;
   logic [31:0] secs = 32'h1234_5678;
   logic        irq, frst, pen;
   logic [14:0] pval;
   logic [PINS-1:0] pdir, ppol;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tamper_supervisor u_tamper_supervisor (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .src_evt_i(src_evt), .pin_evt_i(pin_evt),
      .chip_rst_i(chip_rst), .secs_i(secs), .irq_o(irq), .force_rst_o(frst),
      .presc_en_o(pen), .presc_val_o(pval), .pin_dir_o(pdir), .pin_pol_o(ppol));

   // kinds: 0 bus read, 1 irq, 2 force reset, 3 presc enable, 4 presc value, 5 dir, 6 pol
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = sb.pop_front();
         case (it.kind)
            0: got = bus_rdata;
            1: got = {31'd0, irq};
            2: got = {31'd0, frst};
            3: got = {31'd0, pen};
            4: got = {17'd0, pval};
            5: got = {24'd0, pdir};
            default: got = {24'd0, ppol};
         endcase
         total++;
         if (got !== it.exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", it.tag, got, it.exp);
         end
      end
   end

   task automatic expect_val(input int kind, input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #2;
      bus_addr = a;
      it.kind = kind; it.exp = e; it.tag = tag;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      expect_val(0, a, e, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #2;
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse_src(input int idx);
      @(posedge clk); #2; src_evt = 8'(1 << idx);
      @(posedge clk); #2; src_evt = '0;
   endtask

   task automatic pulse_pin(input int idx);
      @(posedge clk); #2; pin_evt = PINS'(1 << idx);
      @(posedge clk); #2; pin_evt = '0;
   endtask

   task automatic pulse_chip_rst();
      @(posedge clk); #2; chip_rst = 1'b1;
      @(posedge clk); #2; chip_rst = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // reset state
      rd(3'd0, 32'h0, "R11 ctrl after reset");
      rd(3'd1, 32'h0, "R1 status after reset");
      rd(3'd2, 32'h0000_0FF0, "R7 lock after reset");
      expect_val(1, 3'd0, 32'd0, "R4 irq after reset");
      expect_val(2, 3'd0, 32'd0, "R5 force after reset");
      // R12 control fields and pin registers
      wr(3'd0, (32'h1234 << 17) | 32'h2);
      rd(3'd0, 32'h2468_0002, "R12 ctrl readback");
      expect_val(3, 3'd0, 32'd1, "R12 presc enable");
      expect_val(4, 3'd0, 32'h1234, "R12 presc value");
      wr(3'd6, 32'hA5);
      wr(3'd7, 32'h3C);
      expect_val(5, 3'd0, 32'hA5, "R12 pin dir");
      expect_val(6, 3'd0, 32'h3C, "R12 pin pol");
      // R8 polarity lock, then R11 software reset restores everything
      wr(3'd2, 32'h0000_07F0);
      rd(3'd2, 32'h0000_07F0, "R7 lock bit 11 cleared");
      wr(3'd7, 32'hFF);
      expect_val(6, 3'd0, 32'h3C, "R8 pol locked");
      pulse_src(3);
      rd(3'd1, 32'h20, "R1 clock flag");
      wr(3'd0, 32'h1);
      rd(3'd0, 32'h0, "R11 ctrl cleared");
      rd(3'd1, 32'h0, "R11 status cleared");
      rd(3'd2, 32'h0000_0FF0, "R11 locks restored");
      expect_val(5, 3'd0, 32'h0, "R11 dir cleared");
      expect_val(3, 3'd0, 32'd0, "R11 presc off");
      // R1/R2 flag without enable
      pulse_src(2);
      rd(3'd1, 32'h10, "R2 voltage flag, no master");
      wr(3'd5, 32'h10);
      rd(3'd1, 32'h11, "R2 master after enable");
      rd(3'd4, 32'h1234_5678, "R10 seconds captured");
      // R4 interrupts
      wr(3'd3, 32'h1);
      expect_val(1, 3'd0, 32'd1, "R4 irq from master");
      wr(3'd3, 32'h0);
      expect_val(1, 3'd0, 32'd0, "R4 irq disabled");
      wr(3'd3, 32'h10);
      expect_val(1, 3'd0, 32'd1, "R4 irq from source");
      wr(3'd3, 32'h0);
      // R5 forced reset
      wr(3'd0, 32'h4);
      expect_val(2, 3'd0, 32'd1, "R5 force on");
      wr(3'd0, 32'h0);
      expect_val(2, 3'd0, 32'd0, "R5 force off");
      // R3 write-one-to-clear
      wr(3'd1, 32'h1);
      rd(3'd1, 32'h11, "R3 master held by enabled flag");
      wr(3'd1, 32'h10);
      rd(3'd1, 32'h1, "R3 flag cleared master stays");
      wr(3'd1, 32'h1);
      rd(3'd1, 32'h0, "R3 master cleared");
      // R6 acknowledge
      wr(3'd5, 32'h0008_0010);
      pulse_pin(3);
      rd(3'd1, 32'h0008_0001, "R1 pin flag sets master");
      pulse_chip_rst();
      rd(3'd1, 32'h0008_0003, "R6 ack set");
      wr(3'd1, 32'h0008_0003);
      rd(3'd1, 32'h0, "R6 ack cleared with master");
      pulse_chip_rst();
      rd(3'd1, 32'h0, "R6 ack ignores reset without tamper");
      // R8/R9 status lock and update mode
      pulse_src(7);
      rd(3'd1, 32'h200, "R2 test mode flag no master");
      wr(3'd2, 32'h0000_0FD0);
      wr(3'd1, 32'h200);
      rd(3'd1, 32'h200, "R8 status locked");
      wr(3'd0, 32'h8);
      wr(3'd1, 32'h200);
      rd(3'd1, 32'h0, "R9 update mode allows clear");
      wr(3'd5, 32'h4);
      secs = 32'hCAFE_0001;
      pulse_src(0);
      rd(3'd1, 32'h5, "R2 time overflow master");
      rd(3'd4, 32'hCAFE_0001, "R10 seconds recaptured");
      wr(3'd1, 32'h5);
      rd(3'd1, 32'h5, "R9 blocked during tamper");
      // R7 lock behaviour, R8 control and detect-enable locks
      wr(3'd2, 32'h0000_0FFF);
      rd(3'd2, 32'h0000_0FD0, "R7 lock cannot be set");
      wr(3'd2, 32'h0000_0FC0);
      wr(3'd0, 32'h2);
      rd(3'd0, 32'h8, "R8 ctrl locked");
      wr(3'd2, 32'h0000_0DC0);
      wr(3'd5, 32'h0);
      rd(3'd5, 32'h4, "R8 detect enable locked");
      wr(3'd2, 32'h0000_0D80);
      wr(3'd2, 32'h0);
      rd(3'd2, 32'h0000_0D80, "R7 lock register self locked");
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule